// File: doc/BRIEF.md
# Reset Supervisor Timing Controller

This block turns two digitized sensing signals into a clean system reset. One is a flag from an undervoltage comparator, high while the supply sits below its threshold. The other is the level read back from a shared, bidirectional, open-drain reset line. The block runs synchronously on a free-running clock. It can only pull the line low or release it, so any number of devices can share the line. A status output reports whether a reset is in progress.

The supply flag passes through a two-flop synchronizer and then a glitch filter. A dip that is too short to matter is discarded. A sustained dip forces reset at once and holds the hold timer at zero until the supply recovers. After recovery, the line stays low for a full hold period.

Another device can pull the line low to start a manual reset. Only the falling edge of the line level, seen while the block is idle, starts the hold timer. The block releases the line after the hold period. Reset then stays active until the line actually reads high again, so an externally held low extends the reset. The same behaviour lets the block debounce a bouncing switch into one reset pulse of at least the hold period.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, `pin_pull_o` and `rst_active_o` are both 1. After `por_n` rises with the supply good, `pin_pull_o` falls on the HOLD_CYC-th rising clock edge.
- R2: The line is never actively driven high. `pin_pull_o` = 1 means pull low, and whenever `pin_pull_o` is 1, `rst_active_o` is also 1.
- R3: Suppose the block is idle and `uv_flag_i` rises and stays high for more than GLITCH_CYC cycles. Then `pin_pull_o` rises on the (GLITCH_CYC+3)-th rising edge after the flag rises.
- R4: A `uv_flag_i` pulse lasting GLITCH_CYC cycles or fewer has no effect: `pin_pull_o` stays 0.
- R5: While a supply fault is filtered in, the hold timer is kept at zero. After `uv_flag_i` returns low, `pin_pull_o` falls on the (HOLD_CYC+3)-th rising edge. A new sustained dip during the hold restarts this count.
- R6: When the block is idle and the line level falls, `pin_pull_o` rises on the 3rd rising edge after the fall. It then stays high for exactly HOLD_CYC cycles.
- R7: If the line is held low externally past the hold period, `pin_pull_o` is released after HOLD_CYC cycles. `rst_active_o` stays 1 until the line level returns high.
- R8: `rst_active_o` falls on the 3rd rising edge after the line level returns high, once `pin_pull_o` is 0.
- R9: The low level that the block drives itself, and any bounce on the line while a reset is active, never starts another reset. A bouncing press yields exactly one pulse of HOLD_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous power-on initialisation, active low |
| uv_flag_i | input | 1 | Comparator flag, 1 = supply below threshold |
| pin_lvl_i | input | 1 | Sensed level of the open-drain reset line |
| pin_pull_o | output | 1 | Enable for the pull-low driver of the reset line |
| rst_active_o | output | 1 | Reset in progress |

## Verification
Every input crosses two synchronizer flops and one state register, so each response is counted in rising edges from the cycle the stimulus changes:
- a line fall or line release shows up on the 3rd edge;
- a filtered supply fault shows up on edge GLITCH_CYC+3;
- the release after a supply fault comes on edge HOLD_CYC+3;
- the power-on release comes on edge HOLD_CYC.

The bench changes its inputs on falling clock edges. It counts rising edges one by one and reads outputs only on the falling edge that follows each of them. Each measured count is therefore compared with these exact numbers, not with a window. The pulse width is checked as an exact count of HOLD_CYC samples.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_WAIT = 2'd2
  } phase_t;

  // Saturating step of a run-length counter.
  function automatic logic [31:0] run_step(input logic [31:0] cnt, input logic [31:0] cap,
                                           input logic active);
    if (!active)         return 32'd0;
    else if (cnt >= cap) return cap;
    else                 return cnt + 32'd1;
  endfunction

  // A dip counts as real once it has lasted more than lim samples.
  function automatic logic dip_qualifies(input logic [31:0] run, input logic [31:0] lim,
                                         input logic low_now);
    return low_now && (run == lim);
  endfunction

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain <= {STAGES{INIT}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsv_uv_filter.sv
module rsv_uv_filter import rsv_pkg::*; #(
  parameter int GLITCH_CYC = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic uv_s,
  output logic uv_trip,
  output logic uv_filt
);
  localparam int CW = $clog2(GLITCH_CYC + 1);
  localparam logic [31:0] LIM = 32'(GLITCH_CYC);

  logic [CW-1:0] run_q;
  logic [31:0]   run_nx;

  assign run_nx  = run_step(32'(run_q), LIM, uv_s);
  assign uv_trip = dip_qualifies(32'(run_q), LIM, uv_s);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_q   <= '0;
      uv_filt <= 1'b0;
    end else begin
      run_q   <= run_nx[CW-1:0];
      uv_filt <= uv_trip | (uv_filt & uv_s);
    end
  end
endmodule

// File: rtl/rsv_edge_det.sv
module rsv_edge_det (
  input  logic clk,
  input  logic por_n,
  input  logic pin_s,
  input  logic arm,
  output logic man_edge
);
  logic prev_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  assign man_edge = arm & prev_q & ~pin_s;
endmodule

// File: rtl/rsv_hold_ctl.sv
module rsv_hold_ctl import rsv_pkg::*; #(
  parameter int HOLD_CYC = 64
) (
  input  logic clk,
  input  logic por_n,
  input  logic uv_trip,
  input  logic uv_filt,
  input  logic man_edge,
  input  logic pin_s,
  output logic hold_done,
  output logic idle,
  output logic pull,
  output logic active
);
  localparam int HW = $clog2(HOLD_CYC);
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

  phase_t        ph_q;
  logic [HW-1:0] cnt_q;

  assign hold_done = (ph_q == PH_HOLD) && !uv_filt && (cnt_q == LAST);
  assign idle      = (ph_q == PH_IDLE);
  assign pull      = (ph_q == PH_HOLD);
  assign active    = (ph_q != PH_IDLE);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ph_q  <= PH_HOLD;
      cnt_q <= '0;
    end else if (uv_trip || man_edge) begin
      ph_q  <= PH_HOLD;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_HOLD: begin
          if (uv_filt) begin
            cnt_q <= '0;
          end else if (hold_done) begin
            ph_q  <= PH_WAIT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_WAIT: if (pin_s) ph_q <= PH_IDLE;
        default: ph_q <= ph_q;
      endcase
    end
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int HOLD_CYC    = 64,
  parameter int GLITCH_CYC  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic uv_flag_i,
  input  logic pin_lvl_i,
  output logic pin_pull_o,
  output logic rst_active_o
);
  logic uv_s, pin_s;
  logic uv_trip, uv_filt, man_edge, hold_done, idle;

  rsv_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_uv_sync (
    .clk(clk), .por_n(por_n), .d(uv_flag_i), .q(uv_s));

  rsv_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_pin_sync (
    .clk(clk), .por_n(por_n), .d(pin_lvl_i), .q(pin_s));

  rsv_uv_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .por_n(por_n), .uv_s(uv_s), .uv_trip(uv_trip), .uv_filt(uv_filt));

  rsv_edge_det u_edge (
    .clk(clk), .por_n(por_n), .pin_s(pin_s), .arm(idle), .man_edge(man_edge));

  rsv_hold_ctl #(.HOLD_CYC(HOLD_CYC)) u_ctl (
    .clk(clk), .por_n(por_n), .uv_trip(uv_trip), .uv_filt(uv_filt),
    .man_edge(man_edge), .pin_s(pin_s), .hold_done(hold_done), .idle(idle),
    .pull(pin_pull_o), .active(rst_active_o));
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk (
  input logic clk,
  input logic por_n,
  input logic uv_s,
  input logic pin_s,
  input logic uv_trip,
  input logic uv_filt,
  input logic man_edge,
  input logic hold_done,
  input logic pin_pull_o,
  input logic rst_active_o
);
  AST_PULL_IMPLIES_ACTIVE: assert property (@(posedge clk) disable iff (!por_n)
    pin_pull_o |-> rst_active_o); // R2
  AST_TRIP_PULLS: assert property (@(posedge clk) disable iff (!por_n)
    uv_trip |=> pin_pull_o); // R3
  AST_FILT_RELEASES: assert property (@(posedge clk) disable iff (!por_n)
    !uv_s |=> !uv_filt); // R5
  AST_EDGE_PULLS: assert property (@(posedge clk) disable iff (!por_n)
    man_edge |=> pin_pull_o); // R6
  AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pin_pull_o) |-> $past(hold_done)); // R6
  AST_ACTIVE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_active_o) |-> $past(pin_s)); // R8
  AST_NO_EDGE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!por_n)
    rst_active_o |-> !man_edge); // R9
endmodule

bind rst_supervisor rst_supervisor_chk u_chk (
  .clk(clk), .por_n(por_n), .uv_s(uv_s), .pin_s(pin_s), .uv_trip(uv_trip),
  .uv_filt(uv_filt), .man_edge(man_edge), .hold_done(hold_done),
  .pin_pull_o(pin_pull_o), .rst_active_o(rst_active_o));

// File: tb/rst_supervisor_test.sv
`timescale 1ns/1ps
module rst_supervisor_test;
  localparam int H = 64;
  localparam int G = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic uv = 1'b0;
  logic ext_low = 1'b0;
  logic pin_pull, rst_act, pin_lvl;
  int vectors = 0;
  int errors = 0;
  int r2_bad = 0;

  always #2.5 clk = ~clk;

  // Open-drain line with a pull-up: low if anyone pulls.
  assign pin_lvl = ~(pin_pull | ext_low);

  rst_supervisor #(.HOLD_CYC(H), .GLITCH_CYC(G)) uut (
    .clk(clk), .por_n(por_n), .uv_flag_i(uv), .pin_lvl_i(pin_lvl),
    .pin_pull_o(pin_pull), .rst_active_o(rst_act));

  always @(negedge clk) if (por_n && pin_pull && !rst_act) r2_bad++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count rising edges until the chosen output reads val (sampled on falling edges).
  task automatic edges_until(input bit sel_active, input logic val, input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (((sel_active ? rst_act : pin_pull) != val) && n < limit);
  endtask

  task automatic idle_for(input int cyc, output int pulls);
    pulls = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pin_pull) pulls++;
    end
  endtask

  task automatic t_power_on;
    int n;
    @(negedge clk);
    check(pin_pull === 1'b1, "R1 pull during init", int'(pin_pull), 1);
    check(rst_act === 1'b1, "R1 active during init", int'(rst_act), 1);
    por_n = 1'b1;
    edges_until(1'b0, 1'b0, 4*H, n);
    check(n == H, "R1 release edge", n, H);
    edges_until(1'b1, 1'b0, 4*H, n);
    check(n == 3, "R8 active clears after line high", n, 3);
  endtask

  task automatic t_glitch;
    int p;
    uv = 1'b1;
    repeat (G) @(negedge clk);
    uv = 1'b0;
    idle_for(3*G + 10, p);
    check(p == 0, "R4 short dip ignored", p, 0);
  endtask

  task automatic t_uv_trip;
    int n, p;
    uv = 1'b1;
    edges_until(1'b0, 1'b1, 4*G, n);
    check(n == G + 3, "R3 trip latency", n, G + 3);
    idle_for(2*H, p);
    check(p == 2*H, "R5 held while supply low", p, 2*H);
    uv = 1'b0;
    edges_until(1'b0, 1'b0, 4*H, n);
    check(n == H + 3, "R5 release after recovery", n, H + 3);
    edges_until(1'b1, 1'b0, 4*H, n);
    check(n == 3, "R8 active clears after supply release", n, 3);
  endtask

  task automatic t_uv_restart;
    int n;
    uv = 1'b1;
    edges_until(1'b0, 1'b1, 4*G, n);
    uv = 1'b0;
    repeat (H/2) @(negedge clk);
    check(pin_pull === 1'b1, "R5 still holding mid period", int'(pin_pull), 1);
    uv = 1'b1;
    repeat (G + 5) @(negedge clk);
    uv = 1'b0;
    edges_until(1'b0, 1'b0, 4*H, n);
    check(n == H + 3, "R5 restarted hold", n, H + 3);
    edges_until(1'b1, 1'b0, 4*H, n);
  endtask

  task automatic t_manual_short;
    int n, w, p;
    ext_low = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    ext_low = 1'b0;
    edges_until(1'b0, 1'b1, 10, n);
    check(n + 2 == 3, "R6 manual trigger latency", n + 2, 3);
    edges_until(1'b0, 1'b0, 4*H, w);
    check(w == H, "R6 pulse width", w, H);
    edges_until(1'b1, 1'b0, 4*H, n);
    check(n == 3, "R8 active clears after own release", n, 3);
    idle_for(2*H, p);
    check(p == 0, "R9 no retrigger from own drive", p, 0);
  endtask

  task automatic t_manual_long;
    int n, w, a;
    ext_low = 1'b1;
    edges_until(1'b0, 1'b1, 10, n);
    check(n == 3, "R6 long press latency", n, 3);
    edges_until(1'b0, 1'b0, 4*H, w);
    check(w == H, "R7 pull released after hold", w, H);
    a = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rst_act && !pin_pull) a++;
    end
    check(a == 20, "R7 active while held externally", a, 20);
    ext_low = 1'b0;
    edges_until(1'b1, 1'b0, 20, n);
    check(n == 3, "R7 active clears after external release", n, 3);
  endtask

  task automatic t_bounce;
    int rises, hi, p;
    logic last;
    rises = 0; hi = 0; last = 1'b0;
    for (int i = 0; i < 6; i++) begin
      ext_low = (i % 2 == 0);
      @(negedge clk);
      if (pin_pull && !last) rises++;
      if (pin_pull) hi++;
      last = pin_pull;
    end
    ext_low = 1'b0;
    for (int i = 0; i < 3*H; i++) begin
      @(negedge clk);
      if (pin_pull && !last) rises++;
      if (pin_pull) hi++;
      last = pin_pull;
    end
    check(rises == 1, "R9 one pulse from bouncing press", rises, 1);
    check(hi == H, "R9 bounced pulse width", hi, H);
    idle_for(10, p);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_power_on();
    t_glitch();
    t_uv_trip();
    t_uv_restart();
    t_manual_short();
    t_manual_long();
    t_bounce();
    check(r2_bad == 0, "R2 pull only with active", r2_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule